// File: doc/BRIEF.md
# Interrupt Status and Pin Routing Register

This block is the 32-bit interrupt status word of a bus bridge. It gathers several request sources into one readable word: a read-only mailbox summary, a software-controlled local request, a live "outbound queue not empty" compare, two DMA channel request flags, and a set of cross-routing flags. A cross-routing flag records a rising edge seen on one of the four interrupt pins (A, B, C, D) and forwards it as a request on another pin. Software reads the word through `rd_data` and changes it through a single-cycle write (`wr_en`, `wr_data`). Every write completes in the cycle it is presented, so the port has no back-pressure and no handshake.

Each of the four pins has a direction bit. A pin configured as an input supplies events to the routing flags. A pin configured as an output drives a registered, active-high request on `irq_out`. Pin A gathers the summary sources. Pins B, C and D each gather the routing flags aimed at them.

Top module: `irq_route_stat`

## Requirements
- R1: After reset, every implemented status bit and every bit of `irq_out` is 0 (with mailbox flags clear and queue pointers equal).
- R2: Bit 31 reads 1 exactly while any bit of `mbox_flags` is 1. Writes have no effect on it.
- R3: Bit 30 takes the value of `wr_data[30]` on the clock edge of a write and holds it otherwise.
- R4: Bit 27 reads 1 exactly when `q_en` is 1 and `q_head` differs from `q_tail`. No other input changes it.
- R5: Bits 25 and 24 are set by a one-cycle pulse on `dma_evt[1]` and `dma_evt[0]` respectively.
- R6: The routing flag for target pin t (1=B, 2=C, 3=D) and source pin s (0=A .. 3=D), with s different from t, sits at bit 4*t+s: bits 14/13/12 route C/B/A to D, bits 11/9/8 route D/B/A to C, and bits 7/6/4 route D/C/A to B. It sets when `route_en[4*t+s]` is 1, `pin_is_in[s]` is 1, and a rising edge of pin s arrives after its SYNC_STAGES-flop synchronizer.
- R7: A routing flag does not set when its source pin is configured as an output or its route enable is 0.
- R8: Routing and DMA flags clear when 1 is written to their bit, and writing 0 leaves them unchanged. A set event in the same cycle as a clear wins.
- R9: Bits 29, 28, 26, 23 to 15, 10, 5 and 3 to 0 always read 0, whatever is written.
- R10: One rising edge of a pin sets a flag once. A pin held high does not set the flag again after it is cleared.
- R11: `irq_out[0]` is the OR of bits 31, 30, 27, 25 and 24. `irq_out[t]` for t = 1..3 is the OR of the routing flags at bits 4*t to 4*t+3. Each output appears one clock after its status bits and is 0 while `pin_is_in` for that pin is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the status word |
| wr_data | input | 32 | Write value |
| rd_data | output | 32 | Current status word |
| mbox_flags | input | MBOX_W | Mailbox read and write status flags |
| q_en | input | 1 | Queue feature enable |
| q_head | input | PTR_W | Outbound queue head pointer |
| q_tail | input | PTR_W | Outbound queue tail pointer |
| dma_evt | input | 2 | DMA channel request pulses (bit 1 = channel 1) |
| pin_lvl | input | 4 | Raw interrupt pin levels, index 0 = A |
| pin_is_in | input | 4 | Pin direction, 1 = input |
| route_en | input | 16 | Route enables, indexed like the status bits 15..0 |
| irq_out | output | 4 | Registered request per pin |

## Verification
The bench builds the block with SYNC_STAGES = 3, MBOX_W = 4 and PTR_W = 3. The deeper synchronizer makes the event latency visible as something other than the default. The narrow pointers let random head and tail values collide often, so both states of the queue bit are covered. The small mailbox makes "all flags clear" a frequent state under random stimulus. A behavioural model with its own pin-history pipeline predicts every status bit and output on each clock. Directed sequences cover set-versus-clear collisions, held pins, output-configured sources and disabled routes.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
  localparam int NPIN       = 4;
  localparam int STAT_W     = 32;
  localparam int ROUTE_W    = NPIN * NPIN;
  localparam int MBOX_BIT   = 31;
  localparam int LOCAL_BIT  = 30;
  localparam int QUEUE_BIT  = 27;
  localparam int DMA0_BIT   = 24;
  localparam int DMA_N      = 2;

  // a route bit is valid when its target is not pin A and not its own source
  function automatic logic route_valid(input int b);
    int tgt;
    int src;
    tgt = b / NPIN;
    src = b % NPIN;
    return (b < ROUTE_W) && (tgt != 0) && (tgt != src);
  endfunction

  function automatic logic [STAT_W-1:0] route_mask();
    logic [STAT_W-1:0] m;
    m = '0;
    for (int b = 0; b < ROUTE_W; b++) m[b] = route_valid(b);
    return m;
  endfunction

  localparam logic [STAT_W-1:0] ROUTE_MASK = route_mask();
  localparam logic [STAT_W-1:0] DMA_MASK   = {{(STAT_W-DMA_N){1'b0}}, {DMA_N{1'b1}}} << DMA0_BIT;
  localparam logic [STAT_W-1:0] WRITE_MASK = ROUTE_MASK | DMA_MASK | (STAT_W'(1) << LOCAL_BIT);
  localparam logic [STAT_W-1:0] IMPL_MASK  = WRITE_MASK | (STAT_W'(1) << MBOX_BIT)
                                             | (STAT_W'(1) << QUEUE_BIT);
endpackage

// File: rtl/irq_pin_sync.sv
module irq_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_lvl,
  output logic rise
);
  logic [STAGES-1:0] chain;
  logic              last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= '0;
      last  <= 1'b0;
    end else begin
      chain[0] <= pin_lvl;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
      last <= chain[STAGES-1];
    end
  end

  assign rise = chain[STAGES-1] & ~last;

  // R10
  single_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/irq_sticky_bit.sv
module irq_sticky_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= 1'b0;
    else if (set) q <= 1'b1;
    else if (clr) q <= 1'b0;
  end

  // R8
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> q);
  // R8
  clear_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !set) |=> !q);
  // R7
  no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!set && !q) |=> !q);
endmodule

// File: rtl/irq_pin_drive.sv
module irq_pin_drive (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic dir_in,
  output logic out
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out <= 1'b0;
    else        out <= req & ~dir_in;
  end

  // R11
  input_pin_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dir_in |=> !out);
  // R11
  no_req_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req |=> !out);
endmodule

// File: rtl/irq_route_stat.sv
module irq_route_stat
  import irq_route_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int MBOX_W      = 8,
  parameter int PTR_W       = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [STAT_W-1:0] wr_data,
  output logic [STAT_W-1:0] rd_data,
  input  logic [MBOX_W-1:0] mbox_flags,
  input  logic              q_en,
  input  logic [PTR_W-1:0]  q_head,
  input  logic [PTR_W-1:0]  q_tail,
  input  logic [DMA_N-1:0]  dma_evt,
  input  logic [NPIN-1:0]   pin_lvl,
  input  logic [NPIN-1:0]   pin_is_in,
  input  logic [ROUTE_W-1:0] route_en,
  output logic [NPIN-1:0]   irq_out
);
  logic [NPIN-1:0]    pin_rise;
  logic [ROUTE_W-1:0] route_q;
  logic [ROUTE_W-1:0] route_unused;
  logic [DMA_N-1:0]   dma_q;
  logic               local_q;
  logic               mbox_any;
  logic               queue_ne;
  logic [NPIN-1:0]    pin_req;
  logic               unused_wr;

  assign unused_wr = ^(wr_data & ~WRITE_MASK) ^ ^route_unused;

  assign mbox_any = |mbox_flags;
  assign queue_ne = q_en && (q_head != q_tail);

  // pin edge detectors
  for (genvar p = 0; p < NPIN; p++) begin : g_sync
    irq_pin_sync #(.STAGES(SYNC_STAGES)) sync_i (
      .clk(clk), .rst_n(rst_n), .pin_lvl(pin_lvl[p]), .rise(pin_rise[p]));
  end

  // routing flags
  for (genvar b = 0; b < ROUTE_W; b++) begin : g_route
    localparam int TGT = b / NPIN;
    localparam int SRC = b % NPIN;
    if (TGT != 0 && TGT != SRC) begin : g_live
      irq_sticky_bit flag_i (
        .clk(clk), .rst_n(rst_n),
        .set(route_en[b] & pin_is_in[SRC] & pin_rise[SRC]),
        .clr(wr_en & wr_data[b]),
        .q(route_q[b]));
      assign route_unused[b] = 1'b0;
    end else begin : g_hole
      assign route_q[b]      = 1'b0;
      assign route_unused[b] = route_en[b];
    end
  end

  // DMA flags
  for (genvar c = 0; c < DMA_N; c++) begin : g_dma
    irq_sticky_bit flag_i (
      .clk(clk), .rst_n(rst_n),
      .set(dma_evt[c]),
      .clr(wr_en & wr_data[DMA0_BIT+c]),
      .q(dma_q[c]));
  end

  // local request follows the written value
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     local_q <= 1'b0;
    else if (wr_en) local_q <= wr_data[LOCAL_BIT];
  end

  always_comb begin
    rd_data                  = '0;
    rd_data[ROUTE_W-1:0]     = route_q;
    rd_data[DMA0_BIT +: DMA_N] = dma_q;
    rd_data[QUEUE_BIT]       = queue_ne;
    rd_data[LOCAL_BIT]       = local_q;
    rd_data[MBOX_BIT]        = mbox_any;
  end

  // per-pin request and output drive
  for (genvar t = 0; t < NPIN; t++) begin : g_pin
    if (t == 0) begin : g_sum
      assign pin_req[t] = mbox_any | local_q | queue_ne | (|dma_q)
                          | (|route_q[NPIN-1:0]);
    end else begin : g_rt
      assign pin_req[t] = |route_q[NPIN*t +: NPIN];
    end
    irq_pin_drive drive_i (
      .clk(clk), .rst_n(rst_n), .req(pin_req[t]), .dir_in(pin_is_in[t]),
      .out(irq_out[t]));
  end

  // R9
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data & ~IMPL_MASK) == '0);
  // R3
  local_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (rd_data[LOCAL_BIT] == $past(wr_data[LOCAL_BIT])));
  // R3
  local_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(rd_data[LOCAL_BIT]));
  // R2
  mbox_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mbox_flags == '0) |-> !rd_data[MBOX_BIT]);
endmodule

// File: tb/irq_route_stat_tb_top.sv
module irq_route_stat_tb_top;
  localparam int SYNC = 3;
  localparam int MW   = 4;
  localparam int PW   = 3;
  localparam logic [31:0] RT_MASK = 32'h0000_7BD0;
  localparam logic [31:0] IMPL    = 32'hCB00_7BD0;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [MW-1:0] mbox_flags = '0;
  logic        q_en = 1'b0;
  logic [PW-1:0] q_head = '0;
  logic [PW-1:0] q_tail = '0;
  logic [1:0]  dma_evt = '0;
  logic [3:0]  pin_lvl = '0;
  logic [3:0]  pin_is_in = '0;
  logic [15:0] route_en = '0;
  logic [3:0]  irq_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  irq_route_stat #(.SYNC_STAGES(SYNC), .MBOX_W(MW), .PTR_W(PW)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .mbox_flags(mbox_flags), .q_en(q_en), .q_head(q_head), .q_tail(q_tail),
    .dma_evt(dma_evt), .pin_lvl(pin_lvl), .pin_is_in(pin_is_in),
    .route_en(route_en), .irq_out(irq_out));

  // behavioural reference model
  logic [3:0]  m_pipe [SYNC];
  logic [3:0]  m_prev;
  logic [15:0] m_route;
  logic [1:0]  m_dma;
  logic        m_local;
  logic [3:0]  m_out;

  function automatic logic [31:0] model_word();
    logic [31:0] w;
    w = '0;
    w[31] = (mbox_flags != 0);
    w[30] = m_local;
    w[27] = q_en && (q_head != q_tail);
    w[25] = m_dma[1];
    w[24] = m_dma[0];
    w[15:0] = m_route & RT_MASK[15:0];
    return w;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC; i++) m_pipe[i] = '0;
      m_prev = '0; m_route = '0; m_dma = '0; m_local = 1'b0; m_out = '0;
    end else begin
      logic [3:0]  evt;
      logic [31:0] w;
      w = model_word();
      evt = m_pipe[SYNC-1] & ~m_prev;
      m_out[0] = !pin_is_in[0] && (w[31] || w[30] || w[27] || w[25] || w[24]);
      for (int t = 1; t < 4; t++)
        m_out[t] = !pin_is_in[t] && (w[4*t +: 4] != 0);
      for (int b = 4; b < 16; b++) begin
        int t;
        int s;
        t = b / 4;
        s = b % 4;
        if (t != s) begin
          if (route_en[b] && pin_is_in[s] && evt[s]) m_route[b] = 1'b1;
          else if (wr_en && wr_data[b])             m_route[b] = 1'b0;
        end
      end
      for (int c = 0; c < 2; c++) begin
        if (dma_evt[c])                   m_dma[c] = 1'b1;
        else if (wr_en && wr_data[24+c])  m_dma[c] = 1'b0;
      end
      if (wr_en) m_local = wr_data[30];
      m_prev = m_pipe[SYNC-1];
      for (int i = SYNC-1; i > 0; i--) m_pipe[i] = m_pipe[i-1];
      m_pipe[0] = pin_lvl;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // compare on every clock, away from the active edge
  bit live = 1'b0;
  always @(negedge clk) begin
    if (live) begin
      logic [31:0] w;
      w = model_word();
      chk("R2 mailbox", {31'b0, rd_data[31]}, {31'b0, w[31]});
      chk("R3 local",   {31'b0, rd_data[30]}, {31'b0, w[30]});
      chk("R4 queue",   {31'b0, rd_data[27]}, {31'b0, w[27]});
      chk("R5 dma",     {30'b0, rd_data[25:24]}, {30'b0, w[25:24]});
      chk("R6 route",   rd_data & RT_MASK, w & RT_MASK);
      chk("R9 reserved", rd_data & ~IMPL, 32'h0);
      chk("R11 irq_out", {28'b0, irq_out}, {28'b0, m_out});
    end
  end

  task automatic step(input int n = 1);
    repeat (n) begin
      @(posedge clk);
      #2;
    end
  endtask

  task automatic wr(input logic [31:0] d);
    wr_en = 1'b1; wr_data = d;
    step();
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic pulse_pin(input int p);
    pin_lvl[p] = 1'b1;
    step(SYNC + 3);
    pin_lvl[p] = 1'b0;
    step(SYNC + 2);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset word", rd_data, 32'h0);
    chk("R1 reset out", {28'b0, irq_out}, 32'h0);
    live = 1'b1;
    step();

    // R2: summary follows flags, write ignored
    mbox_flags = 4'b0100; step();
    @(negedge clk); chk("R2 set", {31'b0, rd_data[31]}, 32'h1);
    mbox_flags = '0; wr(32'h8000_0000);
    @(negedge clk); chk("R2 write ignored", {31'b0, rd_data[31]}, 32'h0);

    // R3: local bit follows written value
    wr(32'h4000_0000); step(2);
    @(negedge clk); chk("R3 one", {31'b0, rd_data[30]}, 32'h1);
    chk("R11 pin A from local", {31'b0, irq_out[0]}, 32'h1);
    wr(32'h0);
    @(negedge clk); chk("R3 zero", {31'b0, rd_data[30]}, 32'h0);

    // R4: queue compare under enable
    q_en = 1'b1; q_head = 3'd3; q_tail = 3'd3; step();
    @(negedge clk); chk("R4 equal", {31'b0, rd_data[27]}, 32'h0);
    q_head = 3'd4; step();
    @(negedge clk); chk("R4 differ", {31'b0, rd_data[27]}, 32'h1);
    q_en = 1'b0; step();
    @(negedge clk); chk("R4 disabled", {31'b0, rd_data[27]}, 32'h0);
    q_head = '0; q_tail = '0;

    // R5 and R8: DMA set, clear, collision, write of 0
    dma_evt = 2'b01; step(); dma_evt = '0; step();
    @(negedge clk); chk("R5 ch0", {30'b0, rd_data[25:24]}, 32'h1);
    wr(32'h0100_0000);
    @(negedge clk); chk("R8 clear", {30'b0, rd_data[25:24]}, 32'h0);
    dma_evt = 2'b10; step(); dma_evt = '0;
    dma_evt = 2'b10; wr_en = 1'b1; wr_data = 32'h0200_0000; step();
    dma_evt = '0; wr_en = 1'b0; wr_data = '0;
    @(negedge clk); chk("R8 set wins", {30'b0, rd_data[25:24]}, 32'h2);
    wr(32'h0);
    @(negedge clk); chk("R8 write 0 keeps", {30'b0, rd_data[25:24]}, 32'h2);
    wr(32'h0200_0000);

    // R6: pin C routed to B and D
    pin_is_in = 4'hF; route_en = 16'hFFFF; step();
    pulse_pin(2);
    @(negedge clk); chk("R6 C routes", rd_data & RT_MASK, 32'h0000_4040);
    wr(32'h0000_7BD0);

    // R10: held pin sets once
    pin_lvl[0] = 1'b1; step(SYNC + 3);
    @(negedge clk); chk("R10 first", rd_data & RT_MASK, 32'h0000_1110);
    wr(32'h0000_7BD0); step(6);
    @(negedge clk); chk("R10 held no reset", rd_data & RT_MASK, 32'h0);
    pin_lvl[0] = 1'b0; step(SYNC + 2);

    // R7: source configured as output, and disabled route
    pin_is_in = 4'b1101; pulse_pin(1);
    @(negedge clk); chk("R7 output source", rd_data & RT_MASK, 32'h0);
    pin_is_in = 4'hF; route_en[8] = 1'b0; pulse_pin(0);
    @(negedge clk); chk("R7 disabled route", rd_data & RT_MASK, 32'h0000_1010);

    // R11: pin B drives only as output
    pin_is_in = 4'b1101; step(2);
    @(negedge clk); chk("R11 B out", {31'b0, irq_out[1]}, 32'h1);
    pin_is_in = 4'hF; step();
    @(negedge clk); chk("R11 B input", {31'b0, irq_out[1]}, 32'h0);

    // R9: all-ones write keeps reserved bits at 0
    wr(32'hFFFF_FFFF);
    @(negedge clk); chk("R9 after ones", rd_data & ~IMPL, 32'h0);
    wr(32'h0);

    // random traffic
    route_en = 16'hFFFF;
    for (int i = 0; i < 3000; i++) begin
      mbox_flags = ($urandom % 4 == 0) ? MW'($urandom) : '0;
      q_en = 1'($urandom); q_head = PW'($urandom); q_tail = PW'($urandom);
      dma_evt = ($urandom % 8 == 0) ? 2'($urandom) : 2'b0;
      if ($urandom % 3 == 0) pin_lvl = 4'($urandom);
      if ($urandom % 50 == 0) pin_is_in = 4'($urandom);
      if ($urandom % 40 == 0) route_en = 16'($urandom);
      wr_en = ($urandom % 10 == 0);
      wr_data = $urandom;
      step();
    end
    wr_en = 1'b0;
    step(2);
    live = 1'b0;
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule